// File: doc/BRIEF.md
# Masked BCD Alarm Comparator

This block watches a running calendar and raises an alarm interrupt when the time reaches a programmed value. It receives the current time as BCD fields and a strobe that pulses for one cycle each time the calendar moves forward by one second. The time fields are seconds, minutes, hours, day of month, a month code and a three-digit year. On each strobe it compares every enabled field against its alarm register. If at least one enabled field matches, it sets a sticky pending flag and drives the interrupt line high.

Software programs the block through a simple register port. There is a control register, six alarm value registers and a status register. Each alarm register keeps only as many bits as its field needs. The pending flag is cleared by writing a one to its status bit. The calendar itself and any periodic tick timer live outside this block. The register port has no back-pressure: a write is accepted in any cycle where `wr_en_i` is high. Reads are combinational from `rd_addr_i`.

Register addresses (3-bit): 0 control, 1 seconds, 2 minutes, 3 hours, 4 day of month, 5 month, 6 year, 7 status.

Top module: `bcd_alarm_match`

## Requirements
- R1: After reset, every register reads zero and `alarm_irq_o` is low. This covers control, the six alarm values and status.
- R2: A write keeps only a field's low bits. Seconds and minutes keep 7 bits, hours and day keep 6, month keeps 5, year keeps 12, and control keeps 7. A read returns the stored value, zero-extended.
- R3: In a cycle with `tick_i` high and control bit 6 set, the alarm fires if any field whose enable bit is set equals its alarm register. The enable bits are bit 0 seconds, bit 1 minutes, bit 2 hours, bit 3 day, bit 4 month and bit 5 year. The match of one enabled field is enough even when other enabled fields differ. After the next clock edge, status bit 1 reads 1 and `alarm_irq_o` is high.
- R4: No alarm fires in a cycle with `tick_i` low, whatever the time inputs are.
- R5: With control bit 6 clear, no alarm fires, even if enabled fields match.
- R6: A field whose enable bit is clear never causes a fire, even when it matches.
- R7: Once set, the pending flag and `alarm_irq_o` stay high across later ticks until cleared. `alarm_irq_o` always equals status bit 1.
- R8: Writing status with bit 1 set clears the pending flag and lowers `alarm_irq_o` after the edge. A status write with bit 1 clear has no effect.
- R9: If a fire and a clearing status write fall in the same cycle, the pending flag stays set.
- R10: The year compares as the full 12-bit three-digit BCD value, so a mismatch only in the hundreds digit does not fire. The month compares against `cur_mon_i` exactly as given, as a 0-based BCD code.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | One-cycle strobe after each one-second calendar advance |
| cur_sec_i | input | 7 | Current seconds, BCD |
| cur_min_i | input | 7 | Current minutes, BCD |
| cur_hour_i | input | 6 | Current hours, BCD |
| cur_day_i | input | 6 | Current day of month, BCD |
| cur_mon_i | input | 5 | Current month code, 0-based BCD |
| cur_year_i | input | 12 | Current year, three BCD digits |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register write address |
| wr_data_i | input | 12 | Register write data |
| rd_addr_i | input | 3 | Register read address |
| rd_data_o | output | 12 | Register read data |
| alarm_irq_o | output | 1 | Alarm interrupt, level |

## Verification
The hardest case to reach is a single cycle that carries a tick, a matching enabled field and a clearing status write all at once. It also needs the global enable set and the pending flag already high. The directed part builds this case on purpose. The random part draws each time field from its alarm register half the time, so matches are frequent. It also keeps the global enable set in most control writes, and it lets status writes land on tick cycles. That is how fire, clear and hold overlap in many combinations.

// File: rtl/bcd_alarm_pkg.sv
package bcd_alarm_pkg;
  localparam int NUM_FIELDS = 6;
  localparam int FW         = 12;
  localparam int CTRL_W     = 7;
  localparam int ADDR_W     = 3;
  localparam int GLOBAL_BIT = 6;
  localparam int PEND_BIT   = 1;

  localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd7;

  typedef logic [FW-1:0] field_t;
  typedef logic [NUM_FIELDS-1:0][FW-1:0] field_vec_t;

  function automatic int field_bits(int idx);
    case (idx)
      0, 1:    return 7;
      2, 3:    return 6;
      4:       return 5;
      default: return 12;
    endcase
  endfunction

  function automatic field_t field_mask(int idx);
    return field_t'((1 << field_bits(idx)) - 1);
  endfunction
endpackage

// File: rtl/alm_regs.sv
module alm_regs
  import bcd_alarm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  wr_en,
  input  logic [ADDR_W-1:0]     wr_addr,
  input  logic [DATA_W-1:0]     wr_data,
  output logic [CTRL_W-1:0]     ctrl_q,
  output field_vec_t            alm_q
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctrl_q <= '0;
    else if (wr_en && wr_addr == A_CTRL) ctrl_q <= wr_data[CTRL_W-1:0];
  end

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_field
    localparam field_t MASK = field_mask(g);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) alm_q[g] <= '0;
      else if (wr_en && wr_addr == ADDR_W'(g + 1))
        alm_q[g] <= wr_data[FW-1:0] & MASK;
    end
  end
endmodule

// File: rtl/alm_match.sv
module alm_match
  import bcd_alarm_pkg::*;
(
  input  logic              tick,
  input  logic [CTRL_W-1:0] ctrl,
  input  field_vec_t        alm,
  input  field_vec_t        cur,
  output logic              fire
);
  logic [NUM_FIELDS-1:0] hit;

  for (genvar g = 0; g < NUM_FIELDS; g++) begin : g_cmp
    assign hit[g] = ctrl[g] && (cur[g] == alm[g]);
  end

  assign fire = tick && ctrl[GLOBAL_BIT] && (|hit);
endmodule

// File: rtl/alm_pending.sv
module alm_pending (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  input  logic clr,
  output logic pending
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    pending <= 1'b0;
    else if (fire) pending <= 1'b1;
    else if (clr)  pending <= 1'b0;
  end

  AST_FIRE_SETS: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> pending); // R3
  AST_CLEAR_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && !fire) |=> !pending); // R8
  AST_STICKY_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!fire && !clr) |=> $stable(pending)); // R7
  AST_FIRE_BEATS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && clr) |=> pending); // R9
endmodule

// File: rtl/bcd_alarm_match.sv
module bcd_alarm_match
  import bcd_alarm_pkg::*;
#(
  parameter int DATA_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick_i,
  input  logic [6:0]        cur_sec_i,
  input  logic [6:0]        cur_min_i,
  input  logic [5:0]        cur_hour_i,
  input  logic [5:0]        cur_day_i,
  input  logic [4:0]        cur_mon_i,
  input  logic [11:0]       cur_year_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic [ADDR_W-1:0] rd_addr_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              alarm_irq_o
);
  logic [CTRL_W-1:0] ctrl_q;
  field_vec_t        alm_q;
  field_vec_t        cur;
  logic              fire;
  logic              clr;
  logic              pending;

  initial begin
    if (DATA_W < FW) $error("DATA_W must hold the year field");
  end

  assign cur[0] = FW'(cur_sec_i);
  assign cur[1] = FW'(cur_min_i);
  assign cur[2] = FW'(cur_hour_i);
  assign cur[3] = FW'(cur_day_i);
  assign cur[4] = FW'(cur_mon_i);
  assign cur[5] = cur_year_i;

  alm_regs #(.DATA_W(DATA_W)) regs_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en_i),
    .wr_addr (wr_addr_i),
    .wr_data (wr_data_i),
    .ctrl_q  (ctrl_q),
    .alm_q   (alm_q)
  );

  alm_match match_i (
    .tick (tick_i),
    .ctrl (ctrl_q),
    .alm  (alm_q),
    .cur  (cur),
    .fire (fire)
  );

  assign clr = wr_en_i && (wr_addr_i == A_STAT) && wr_data_i[PEND_BIT];

  alm_pending pend_i (
    .clk     (clk),
    .rst_n   (rst_n),
    .fire    (fire),
    .clr     (clr),
    .pending (pending)
  );

  assign alarm_irq_o = pending;

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == A_CTRL) begin
      rd_data_o[CTRL_W-1:0] = ctrl_q;
    end else if (rd_addr_i == A_STAT) begin
      rd_data_o[PEND_BIT] = pending;
    end else begin
      for (int i = 0; i < NUM_FIELDS; i++)
        if (rd_addr_i == ADDR_W'(i + 1)) rd_data_o[FW-1:0] = alm_q[i];
    end
  end

  AST_NO_RISE_WITHOUT_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !tick_i |=> !$rose(alarm_irq_o)); // R4
  AST_GLOBAL_GATE: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q[GLOBAL_BIT] |=> !$rose(alarm_irq_o)); // R5
endmodule

// File: tb/bcd_alarm_match_tb.sv
module bcd_alarm_match_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        tick_i = 1'b0;
  logic [6:0]  cur_sec_i = '0, cur_min_i = '0;
  logic [5:0]  cur_hour_i = '0, cur_day_i = '0;
  logic [4:0]  cur_mon_i = '0;
  logic [11:0] cur_year_i = '0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [11:0] wr_data_i = '0;
  logic [2:0]  rd_addr_i = '0;
  logic [11:0] rd_data_o;
  logic        alarm_irq_o;

  int n_tests = 0;
  int n_fail  = 0;

  logic [6:0]  m_ctrl = '0;
  logic [11:0] m_alm [6] = '{default: '0};
  logic        m_pend = 1'b0;
  logic [11:0] t_f [6] = '{default: '0};

  always #2.5 clk = ~clk;

  bcd_alarm_match dut_i (
    .clk(clk), .rst_n(rst_n), .tick_i(tick_i),
    .cur_sec_i(cur_sec_i), .cur_min_i(cur_min_i), .cur_hour_i(cur_hour_i),
    .cur_day_i(cur_day_i), .cur_mon_i(cur_mon_i), .cur_year_i(cur_year_i),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .rd_addr_i(rd_addr_i), .rd_data_o(rd_data_o), .alarm_irq_o(alarm_irq_o)
  );

  function automatic logic [11:0] fmask(int i);
    case (i)
      0, 1:    return 12'h07F;
      2, 3:    return 12'h03F;
      4:       return 12'h01F;
      default: return 12'hFFF;
    endcase
  endfunction

  function automatic logic [11:0] exp_read(logic [2:0] a);
    if (a == 3'd0) return {5'd0, m_ctrl};
    if (a == 3'd7) return {10'd0, m_pend, 1'b0};
    return m_alm[int'(a) - 1];
  endfunction

  function automatic bit exp_fire(bit tk);
    bit any = 1'b0;
    for (int i = 0; i < 6; i++)
      if (m_ctrl[i] && ((t_f[i] & fmask(i)) == m_alm[i])) any = 1'b1;
    return tk && m_ctrl[6] && any;
  endfunction

  task automatic check(bit ok, string tag, logic [11:0] act, logic [11:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(logic [2:0] a, string tag);
    rd_addr_i = a;
    #0.5;
    check(rd_data_o == exp_read(a), tag, rd_data_o, exp_read(a));
  endtask

  // one cycle: called right after a falling edge, returns after the next one
  task automatic step(bit w, logic [2:0] a, logic [11:0] d, bit tk, string tag);
    bit f, c;
    wr_en_i = w; wr_addr_i = a; wr_data_i = d; tick_i = tk;
    cur_sec_i = t_f[0][6:0]; cur_min_i = t_f[1][6:0];
    cur_hour_i = t_f[2][5:0]; cur_day_i = t_f[3][5:0];
    cur_mon_i = t_f[4][4:0]; cur_year_i = t_f[5];
    f = exp_fire(tk);
    c = w && a == 3'd7 && d[1];
    @(negedge clk);
    m_pend = f | (m_pend & ~c);
    if (w && a == 3'd0) m_ctrl = d[6:0];
    else if (w && a != 3'd7) m_alm[int'(a) - 1] = d & fmask(int'(a) - 1);
    wr_en_i = 1'b0; tick_i = 1'b0;
    check(alarm_irq_o == m_pend, tag, {11'd0, alarm_irq_o}, {11'd0, m_pend});
  endtask

  task automatic set_time(logic [11:0] s, logic [11:0] mi, logic [11:0] h,
                          logic [11:0] dy, logic [11:0] mo, logic [11:0] y);
    t_f[0] = s; t_f[1] = mi; t_f[2] = h; t_f[3] = dy; t_f[4] = mo; t_f[5] = y;
  endtask

  initial begin
    #(5.0 * 150000);
    n_tests++; n_fail++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int unsigned seed;
    seed = $urandom(32'h5EED_0A1A);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset values
    for (int a = 0; a < 8; a++) rd_chk(3'(a), "R1 reset read");
    check(alarm_irq_o == 1'b0, "R1 irq low", {11'd0, alarm_irq_o}, 12'd0);

    // R2 width masking on write and readback
    step(1, 3'd0, 12'hFFF, 0, "R2 ctrl write");
    for (int a = 1; a < 7; a++) step(1, 3'(a), 12'hFFF, 0, "R2 field write");
    for (int a = 0; a < 7; a++) rd_chk(3'(a), "R2 masked read");
    check(rd_data_o == 12'hFFF, "R2 year 12 bits", rd_data_o, 12'hFFF);
    rd_addr_i = 3'd5; #0.5;
    check(rd_data_o == 12'h01F, "R2 month 5 bits", rd_data_o, 12'h01F);

    // seconds alarm only
    step(1, 3'd0, 12'h000, 0, "R2 ctrl zero");
    step(1, 3'd1, 12'h030, 0, "R3 set sec alarm");
    step(1, 3'd0, 12'h041, 0, "R3 enable sec");
    set_time(12'h29, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R6 no match no fire");
    set_time(12'h30, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 0, "R4 match without tick");
    check(alarm_irq_o == 1'b0, "R4 irq still low", {11'd0, alarm_irq_o}, 12'd0);
    step(0, 3'd0, 12'h0, 1, "R3 seconds fire");
    check(alarm_irq_o == 1'b1, "R3 irq high", {11'd0, alarm_irq_o}, 12'd1);
    rd_chk(3'd7, "R7 status bit1");

    // R7 sticky, R8 write-one-to-clear
    set_time(12'h31, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R7 sticky");
    step(1, 3'd7, 12'hFFD, 0, "R8 write zero to bit1");
    check(alarm_irq_o == 1'b1, "R8 no effect", {11'd0, alarm_irq_o}, 12'd1);
    step(1, 3'd7, 12'h002, 0, "R8 clear");
    check(alarm_irq_o == 1'b0, "R8 irq dropped", {11'd0, alarm_irq_o}, 12'd0);

    // R5 global gate
    step(1, 3'd0, 12'h03F, 0, "R5 enables without global");
    set_time(12'h30, 12'h0, 12'h0, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R5 match gated");
    check(alarm_irq_o == 1'b0, "R5 no fire", {11'd0, alarm_irq_o}, 12'd0);

    // R6 disabled field matching, R3 OR of one field among mismatches
    step(1, 3'd2, 12'h045, 0, "R3 set min alarm");
    step(1, 3'd3, 12'h012, 0, "R3 set hour alarm");
    step(1, 3'd0, 12'h046, 0, "R6 min+hour enabled");
    set_time(12'h30, 12'h44, 12'h11, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R6 disabled sec match");
    check(alarm_irq_o == 1'b0, "R6 no fire", {11'd0, alarm_irq_o}, 12'd0);
    set_time(12'h30, 12'h44, 12'h12, 12'h0, 12'h0, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R3 one of two fires");
    check(alarm_irq_o == 1'b1, "R3 OR fire", {11'd0, alarm_irq_o}, 12'd1);

    // R9 fire and clear in the same cycle
    set_time(12'h30, 12'h45, 12'h0, 12'h0, 12'h0, 12'h0);
    wr_en_i = 1'b0;
    step(1, 3'd7, 12'h002, 1, "R9 fire beats clear");
    check(alarm_irq_o == 1'b1, "R9 held", {11'd0, alarm_irq_o}, 12'd1);
    step(1, 3'd7, 12'h002, 0, "R8 clear after");

    // R10 year 12-bit and month code
    step(1, 3'd6, 12'h124, 0, "R10 set year");
    step(1, 3'd5, 12'h011, 0, "R10 set month");
    step(1, 3'd0, 12'h060, 0, "R10 year only");
    set_time(12'h0, 12'h0, 12'h0, 12'h0, 12'h11, 12'h024);
    step(0, 3'd0, 12'h0, 1, "R10 hundreds differ");
    check(alarm_irq_o == 1'b0, "R10 no year fire", {11'd0, alarm_irq_o}, 12'd0);
    set_time(12'h0, 12'h0, 12'h0, 12'h0, 12'h11, 12'h124);
    step(0, 3'd0, 12'h0, 1, "R10 year fire");
    check(alarm_irq_o == 1'b1, "R10 year irq", {11'd0, alarm_irq_o}, 12'd1);
    step(1, 3'd7, 12'h002, 0, "R8 clear");
    step(1, 3'd0, 12'h050, 0, "R10 month only");
    set_time(12'h0, 12'h0, 12'h0, 12'h0, 12'h11, 12'h0);
    step(0, 3'd0, 12'h0, 1, "R10 month code fire");
    check(alarm_irq_o == 1'b1, "R10 month irq", {11'd0, alarm_irq_o}, 12'd1);

    // constrained random
    for (int n = 0; n < 4000; n++) begin
      bit w, tk;
      logic [2:0] a;
      logic [11:0] d;
      w  = ($urandom % 3) == 0;
      a  = 3'($urandom % 8);
      d  = 12'($urandom);
      if (a == 3'd0 && ($urandom % 4) != 0) d[6] = 1'b1;
      tk = ($urandom % 2) == 0;
      for (int i = 0; i < 6; i++)
        t_f[i] = (($urandom % 2) == 0) ? m_alm[i] : (12'($urandom) & fmask(i));
      step(w, a, d, tk, "R3 random irq");
      rd_chk(3'($urandom % 8), "R2 random read");
    end

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule